// File: doc/BRIEF.md
# Half-Bridge Gate Control Sequencer

This block is the clocked control core for one phase of a synchronous buck power stage; a two-phase stage places two copies side by side. It turns a single switching command into two gate enables, one for the high-side switch and one for the low-side switch. Before either switch is allowed on, it waits until the opposite gate is reported fully off. A per-instance timeout releases the wait if that report never comes.

Two mode inputs select between forced continuous switching, pulse skipping and a low-power shutdown state. In pulse skipping, a zero-crossing input ends the low-side conduction early. Separate inputs for an undervoltage condition and an over-temperature condition override the normal sequence. Every input is asynchronous to the clock and passes through a two-flop synchronizer. The analog comparators and gate drivers sit outside the block.

Top module: `halfbridge_gate_seq`

## Requirements
- R1: While `rst_n` is low, both `hi_en` and `lo_en` are 0.
- R2: The block is non-inverting. With the command high, `hi_en` becomes the asserted enable. With the command low, `lo_en` becomes the asserted enable. Output encoding is {hi_en,lo_en}: 10 means high side on, 01 means low side on.
- R3: `hi_en` and `lo_en` are never 1 in the same cycle, and every handover between them passes through at least one cycle with both at 0. A command pulse shorter than the handover leaves `hi_en` at 0.
- R4: An enable rises only after the opposite gate-off feedback (`lo_gate_off` for `hi_en`, `hi_gate_off` for `lo_en`) has been seen through the synchronizer, and never sooner than 2 cycles after the wait starts. With feedback that follows the opposite enable at once, the both-off gap is exactly 3 cycles.
- R5: If the gate-off feedback stays at 0, the waiting enable rises anyway. The both-off gap is then TMO_CYCLES+1 cycles.
- R6: With `cont_mode` high, `zero_cross` is ignored and `lo_en` stays 1 for the whole low-command interval.
- R7: With `cont_mode` low and `run_req` high, `zero_cross` high during a low-side interval drops `lo_en`. It stays 0 for the rest of that interval, even after `zero_cross` returns to 0.
- R8: That truncation clears on the next rising command. The following low-command interval turns `lo_en` on again.
- R9: With `run_req` and `cont_mode` both low, the outputs go to hi_en=0, lo_en=1, whatever the command. If `hi_en` was on, one both-off cycle comes first.
- R10: `run_req` low with `cont_mode` high is an operating mode that follows the command, not shutdown.
- R11: `supply_low` high outside the shutdown combination forces both enables to 0. Inside the shutdown combination, the R9 state applies.
- R12: `over_temp` high forces hi_en=0, lo_en=1, with a both-off cycle first if `hi_en` was on. When it clears, normal sequencing resumes.
- R13: A command edge reaches the outputs on the third clock edge after it is sampled: two synchronizer flops, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 1 | Switching command, high requests the high side |
| run_req | input | 1 | Run request, low together with `cont_mode` low selects shutdown |
| cont_mode | input | 1 | High: forced continuous switching; low: pulse skipping |
| supply_low | input | 1 | Supply below the undervoltage threshold |
| over_temp | input | 1 | Die over-temperature shutdown condition |
| zero_cross | input | 1 | Inductor current has reached zero |
| hi_gate_off | input | 1 | High-side gate sensed fully off |
| lo_gate_off | input | 1 | Low-side gate sensed fully off |
| hi_en | output | 1 | High-side gate enable |
| lo_en | output | 1 | Low-side gate enable |

## Verification
The command is driven in four patterns, and each one separates a different failure:

- Slow square edges show the handover order and the exact both-off gap when feedback tracks the enables.
- A one-cycle glitch shows that a command shorter than the handover never reaches the high side.
- A stuck low-side feedback separates the adaptive release from the timeout release by the length of the gap.
- Toggling the command during shutdown, undervoltage and over-temperature shows that the overrides win over the command.

A zero-crossing pulse given in each mode separates pulse skipping from forced continuous switching. The command edge that follows it shows whether the truncation clears.

// File: rtl/halfbridge_gate_seq.sv
module halfbridge_gate_seq #(
  parameter int TMO_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_in,
  input  logic run_req,
  input  logic cont_mode,
  input  logic supply_low,
  input  logic over_temp,
  input  logic zero_cross,
  input  logic hi_gate_off,
  input  logic lo_gate_off,
  output logic hi_en,
  output logic lo_en
);
  localparam int CNT_W    = $clog2(TMO_CYCLES + 1);
  localparam int SYNC_LAT = 2;
  localparam int NSYNC    = 8;

  logic [NSYNC-1:0] meta, sync;
  logic cmd_s, run_s, cont_s, uv_s, hot_s, zc_s, hoff_s, loff_s;
  logic cmd_q, trunc, trunc_n, hi_n, lo_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic shut, uv_off, force_lo, wait_hi, wait_lo, waiting;
  logic tmo, blank_ok, go_hi, go_lo, trunc_set, cmd_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= {cmd_in, run_req, cont_mode, supply_low, over_temp, zero_cross, hi_gate_off, lo_gate_off};
      sync <= meta;
    end

  assign {cmd_s, run_s, cont_s, uv_s, hot_s, zc_s, hoff_s, loff_s} = sync;

  assign shut      = ~run_s & ~cont_s;
  assign uv_off    = uv_s & ~shut;
  assign force_lo  = shut | (hot_s & ~uv_off);
  assign cmd_rise  = cmd_s & ~cmd_q;
  assign wait_hi   = cmd_s & ~hi_en & ~lo_en;
  assign wait_lo   = ~cmd_s & ~hi_en & ~lo_en & ~trunc;
  assign waiting   = ~force_lo & ~uv_off & (wait_hi | wait_lo);
  assign tmo       = cnt == CNT_W'(TMO_CYCLES);
  assign blank_ok  = cnt >= CNT_W'(SYNC_LAT);
  assign go_hi     = tmo | (blank_ok & loff_s);
  assign go_lo     = tmo | (blank_ok & hoff_s);
  assign trunc_set = ~cont_s & ~cmd_s & zc_s & lo_en;

  always_comb begin
    trunc_n = (cmd_rise | cont_s) ? 1'b0 : (trunc | trunc_set);
    hi_n    = cmd_s & ~lo_en & (hi_en | go_hi);
    lo_n    = ~cmd_s & ~hi_en & ~trunc_n & (lo_en | go_lo);
    cnt_n   = waiting ? (tmo ? cnt : cnt + CNT_W'(1)) : '0;
    if (uv_off) begin
      hi_n    = 1'b0;
      lo_n    = 1'b0;
      trunc_n = 1'b0;
    end else if (force_lo) begin
      hi_n    = 1'b0;
      lo_n    = ~hi_en;
      trunc_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_en <= 1'b0;
      lo_en <= 1'b0;
      trunc <= 1'b0;
      cmd_q <= 1'b0;
      cnt   <= '0;
    end else begin
      hi_en <= hi_n;
      lo_en <= lo_n;
      trunc <= trunc_n;
      cmd_q <= cmd_s;
      cnt   <= cnt_n;
    end
endmodule

// File: rtl/halfbridge_gate_seq_chk.sv
module halfbridge_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_in,
  input logic run_req,
  input logic cont_mode,
  input logic supply_low,
  input logic hi_en,
  input logic lo_en
);
  logic [2:0] age;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;

  assign settled = age == 3'd7;

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_en && lo_en));

  assert_hi_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $rose(hi_en)) |-> $past(!lo_en));

  assert_lo_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $rose(lo_en)) |-> $past(!hi_en));

  assert_hi_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && hi_en) |-> $past(cmd_in, 3));

  assert_shutdown_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $past(!run_req && !cont_mode, 3) && $past(!run_req && !cont_mode, 4))
      |-> (lo_en && !hi_en));

  assert_uv_both_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $past(run_req && supply_low, 3)) |-> (!hi_en && !lo_en));
endmodule

bind halfbridge_gate_seq halfbridge_gate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .run_req(run_req),
  .cont_mode(cont_mode), .supply_low(supply_low), .hi_en(hi_en), .lo_en(lo_en)
);

// File: tb/halfbridge_gate_seq_bench.sv
`timescale 1ns/1ps
module halfbridge_gate_seq_bench;
  localparam int TMO = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_in = 1'b0, run_req = 1'b1, cont_mode = 1'b1;
  logic supply_low = 1'b0, over_temp = 1'b0, zero_cross = 1'b0;
  logic stuck_lo = 1'b0;
  logic hi_gate_off, lo_gate_off, hi_en, lo_en;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string tag_q[$];
  string cur_req = "R1";
  logic [1:0] prev = 2'b00;

  always #4 clk = ~clk;

  assign hi_gate_off = ~hi_en;
  assign lo_gate_off = stuck_lo ? 1'b0 : ~lo_en;

  halfbridge_gate_seq #(.TMO_CYCLES(TMO)) u_halfbridge_gate_seq (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .run_req(run_req),
    .cont_mode(cont_mode), .supply_low(supply_low), .over_temp(over_temp),
    .zero_cross(zero_cross), .hi_gate_off(hi_gate_off), .lo_gate_off(lo_gate_off),
    .hi_en(hi_en), .lo_en(lo_en)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(logic [1:0] s, string tag);
    exp_q.push_back(s);
    tag_q.push_back(tag);
  endtask

  task automatic drain(string tag);
    cyc(30);
    chk({tag, " pending"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic report();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if ({hi_en, lo_en} != prev) begin
        if (exp_q.size() == 0) chk({cur_req, " unexpected change"}, int'({hi_en, lo_en}), int'(prev));
        else chk(tag_q.pop_front(), int'({hi_en, lo_en}), int'(exp_q.pop_front()));
      end
      prev = {hi_en, lo_en};
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk("watchdog", 1, 0);
      report();
    end
  end

  initial begin
    int gap;
    cyc(3);
    chk("R1 reset hi/lo", int'({hi_en, lo_en}), 0);
    cur_req = "R2";
    expect_st(2'b01, "R2 low side with low command");
    rst_n = 1'b1;
    drain("R2");

    cur_req = "R3";
    expect_st(2'b00, "R3 gap before high side");
    expect_st(2'b10, "R2 high side with high command");
    cmd_in = 1'b1;
    cyc(2);
    chk("R13 lo still on after two edges", int'({hi_en, lo_en}), 1);
    cyc(1);
    chk("R13 lo off at third edge", int'({hi_en, lo_en}), 0);
    gap = 0;
    while ({hi_en, lo_en} == 2'b00) begin gap++; cyc(1); end
    chk("R4 gap with prompt feedback", gap, 3);
    drain("R2");

    expect_st(2'b00, "R3 gap before low side");
    expect_st(2'b01, "R2 low side after fall");
    cmd_in = 1'b0;
    drain("R3");

    expect_st(2'b00, "R3 glitch drops low side");
    expect_st(2'b01, "R3 glitch returns low side");
    cmd_in = 1'b1;
    cyc(1);
    cmd_in = 1'b0;
    drain("R3");

    cur_req = "R5";
    stuck_lo = 1'b1;
    expect_st(2'b00, "R5 gap start");
    expect_st(2'b10, "R5 timeout release");
    cmd_in = 1'b1;
    while (lo_en) cyc(1);
    gap = 0;
    while ({hi_en, lo_en} == 2'b00) begin gap++; cyc(1); end
    chk("R5 timeout gap", gap, TMO + 1);
    expect_st(2'b00, "R3 gap after timeout");
    expect_st(2'b01, "R2 low after timeout case");
    cmd_in = 1'b0;
    cyc(20);
    stuck_lo = 1'b0;
    drain("R5");

    cur_req = "R7";
    cont_mode = 1'b0;
    cyc(10);
    expect_st(2'b00, "R7 zero cross truncates");
    zero_cross = 1'b1;
    cyc(3);
    zero_cross = 1'b0;
    cyc(15);
    chk("R7 low side stays off", int'({hi_en, lo_en}), 0);
    cur_req = "R8";
    expect_st(2'b10, "R8 high side after truncation");
    cmd_in = 1'b1;
    cyc(20);
    expect_st(2'b00, "R8 gap");
    expect_st(2'b01, "R8 low side resumes");
    cmd_in = 1'b0;
    drain("R8");

    cur_req = "R6";
    cont_mode = 1'b1;
    cyc(10);
    zero_cross = 1'b1;
    cyc(8);
    chk("R6 zero cross ignored", int'({hi_en, lo_en}), 1);
    zero_cross = 1'b0;
    drain("R6");

    cur_req = "R9";
    expect_st(2'b00, "R3 gap");
    expect_st(2'b10, "R2 high");
    cmd_in = 1'b1;
    drain("R9");
    expect_st(2'b00, "R9 gap into shutdown");
    expect_st(2'b01, "R9 shutdown state");
    run_req = 1'b0;
    cont_mode = 1'b0;
    cyc(10);
    cmd_in = 1'b0;
    cyc(5);
    cmd_in = 1'b1;
    cyc(10);
    chk("R9 command ignored in shutdown", int'({hi_en, lo_en}), 1);
    drain("R9");

    cur_req = "R10";
    expect_st(2'b00, "R10 gap");
    expect_st(2'b10, "R10 operating with run low");
    cont_mode = 1'b1;
    drain("R10");

    cur_req = "R11";
    run_req = 1'b1;
    cyc(10);
    expect_st(2'b00, "R11 undervoltage both off");
    supply_low = 1'b1;
    cyc(10);
    cmd_in = 1'b0;
    cyc(10);
    chk("R11 both off with low command", int'({hi_en, lo_en}), 0);
    expect_st(2'b01, "R11 shutdown wins over undervoltage");
    run_req = 1'b0;
    cont_mode = 1'b0;
    cyc(15);
    supply_low = 1'b0;
    run_req = 1'b1;
    cont_mode = 1'b1;
    drain("R11");

    cur_req = "R12";
    expect_st(2'b00, "R3 gap");
    expect_st(2'b10, "R2 high");
    cmd_in = 1'b1;
    drain("R12");
    expect_st(2'b00, "R12 gap into over temp");
    expect_st(2'b01, "R12 over temp state");
    over_temp = 1'b1;
    cyc(10);
    cmd_in = 1'b0;
    cyc(5);
    cmd_in = 1'b1;
    cyc(10);
    chk("R12 command ignored while hot", int'({hi_en, lo_en}), 1);
    expect_st(2'b00, "R12 release gap");
    expect_st(2'b10, "R12 resumes high");
    over_temp = 1'b0;
    drain("R12");

    report();
  end
endmodule